// File: doc/BRIEF.md
# LED Matrix Bit-Plane Scan Controller

This block scans a row-multiplexed LED matrix that is sixteen columns wide. It builds grayscale from weighted bit-planes: inside one row slot it shows each plane's column pattern in turn. Each plane stays up for its own dwell time, and those unequal dwell times give the planes their weights. Column data comes from an external frame buffer through a combinational read port. The block presents a row and plane address and gets back sixteen bits. It drives the sixteen column enables directly.

The active row is chosen by an external shift register, which the block controls through an active-low clear, a clock and a data strobe. When the scan reaches row 0, the block clears the register and seeds a single one into it. For every later row it gives one clock pulse, which moves the one forward. Around each row change the columns are blanked. A guard interval separates the blanking from the first strobe, and a second guard separates the last strobe from the new column data.

Two parameters select optional remaps. One interleaves the rows of the frame buffer. The other mirrors the sixteen columns. A synchronous enable pauses the whole scan.

Top module: `led_plane_scan`

## Requirements
- R1: After reset the columns are zero and all three row strobes (clear, clock, data) are low. The first dwell lasts (CMP_INIT+1)·PRESCALE cycles, with CMP_INIT = 20 by default. It ends in a row change into row 0.
- R2: Plane p holds its column value for exactly (c_p+1)·PRESCALE cycles. The values c_0, c_1, c_2 are 3, 4 and 22 by default, in field p·8 of PLANE_CMP.
- R3: Within a row the planes are shown in the order 0, 1, …, PLANES−1. Only after the last plane does the row index advance, and it wraps from ROWS−1 to 0.
- R4: At a row change the columns read zero from the cycle after the last plane's dwell. The strobes keep their levels for the first GUARD_PRE+1 blank cycles.
- R5: On entry to row 0 the strobes step once per cycle through this sequence: clear low, clear high, data high, clock high, clock low, data low. As a result the external register holds a one in bit 0 only.
- R6: On entry to any other row exactly one clock pulse of one cycle is issued, with data held low, so the register's single one moves up to bit r.
- R7: After the last strobe change the strobes stay steady and the columns stay blank for GUARD_POST cycles. The blank run therefore lasts GUARD_PRE+n+GUARD_POST cycles, with n = 6 for row 0 and n = 2 otherwise.
- R8: Without remaps, col[7:0] = fb_data[7:0] and col[15:8] = fb_data[15:8], read at fb_row = row and fb_plane = plane.
- R9: With INTERLACE set, the buffer row read for row r is r>>1 when r is even and (r>>1)+ROWS/2 when r is odd.
- R10: With REVERSE set, each data byte is bit-mirrored and the two column groups swap, so that col[i] = fb_data[15−i].
- R11: While en is low, the columns and all strobes are zero and every counter is frozen. Counted over enabled cycles only, the output sequence equals an uninterrupted scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| fb_data | input | 16 | Frame buffer read data for the presented address |
| fb_row | output | $clog2(ROWS) | Frame buffer row address |
| fb_plane | output | $clog2(PLANES) | Frame buffer plane address |
| col | output | 16 | Column enables |
| row_clr_n | output | 1 | Active-low clear of the row shift register |
| row_clk | output | 1 | Row shift register clock |
| row_dat | output | 1 | Row shift register serial data |

## Verification
The disable input can land in the same cycle as a dwell expiry, a guard count or a strobe step of the row-change sequence. The bench provokes this by dropping en for a window in the middle of the scan, at a point it does not steer. During that window it checks that every output is zero. Each of the two monitors, one for the plain variant and one for the variant with both remaps, counts only enabled cycles. It judges the overlap by requiring that dwell lengths, guard spacing, strobe order and plane data still come out exactly as in an unbroken scan. It stops trusting its shift register model until the next row-0 seed, because the forced-low clear empties the real register.

// File: rtl/led_plane_scan.sv
module led_plane_scan #(
  parameter int ROWS       = 16,
  parameter int PLANES     = 3,
  parameter int PRESCALE   = 256,
  parameter logic [PLANES*8-1:0] PLANE_CMP = {8'd22, 8'd4, 8'd3},
  parameter int CMP_INIT   = 20,
  parameter int GUARD_PRE  = 10,
  parameter int GUARD_POST = 20,
  parameter bit INTERLACE  = 1'b0,
  parameter bit REVERSE    = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [15:0]               fb_data,
  output logic [$clog2(ROWS)-1:0]   fb_row,
  output logic [$clog2(PLANES)-1:0] fb_plane,
  output logic [15:0]               col,
  output logic                      row_clr_n,
  output logic                      row_clk,
  output logic                      row_dat
);
  localparam int RW   = $clog2(ROWS);
  localparam int PW   = $clog2(PLANES);
  localparam int TW   = 9 + $clog2(PRESCALE);
  localparam int GMAX = (GUARD_PRE > GUARD_POST) ? GUARD_PRE : GUARD_POST;
  localparam int GW   = $clog2(GMAX + 1);

  typedef enum logic [1:0] {S_DWELL, S_PRE, S_SEQ, S_POST} st_t;

  st_t           st;
  logic [RW-1:0] nr;
  logic [PW-1:0] np;
  logic [TW-1:0] tmr, lim;
  logic [GW-1:0] gc;
  logic [2:0]    k;
  logic [15:0]   col_q, mapped;
  logic          clr_q, clk_q, dat_q;

  function automatic logic [TW-1:0] lim_of(input logic [PW-1:0] p);
    return TW'((int'(PLANE_CMP[int'(p)*8 +: 8]) + 1) * PRESCALE - 1);
  endfunction

  function automatic logic [PW-1:0] p_next(input logic [PW-1:0] p);
    return (p == PW'(PLANES - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    if (REVERSE) begin : g_rev
      for (genvar i = 0; i < 16; i++) begin : g_bit
        assign mapped[i] = fb_data[15-i];
      end
    end else begin : g_fwd
      assign mapped = fb_data;
    end
    if (INTERLACE) begin : g_il
      assign fb_row = nr[0] ? RW'((nr >> 1) + RW'(ROWS / 2)) : RW'(nr >> 1);
    end else begin : g_lin
      assign fb_row = nr;
    end
  endgenerate

  assign fb_plane  = np;
  assign col       = en ? col_q : '0;
  assign row_clr_n = en & clr_q;
  assign row_clk   = en & clk_q;
  assign row_dat   = en & dat_q;

  wire [2:0] k_last = (nr == '0) ? 3'd5 : 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_DWELL;
      nr    <= '0;
      np    <= '0;
      tmr   <= '0;
      lim   <= TW'((CMP_INIT + 1) * PRESCALE - 1);
      gc    <= '0;
      k     <= '0;
      col_q <= '0;
      clr_q <= 1'b0;
      clk_q <= 1'b0;
      dat_q <= 1'b0;
    end else if (en) begin
      case (st)
        S_DWELL:
          if (tmr == lim) begin
            tmr <= '0;
            if (np == '0) begin
              col_q <= '0;
              gc    <= '0;
              st    <= S_PRE;
            end else begin
              col_q <= mapped;
              lim   <= lim_of(np);
              np    <= p_next(np);
              if (np == PW'(PLANES - 1))
                nr <= (nr == RW'(ROWS - 1)) ? '0 : nr + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_PRE:
          if (gc == GW'(GUARD_PRE - 1)) begin
            gc <= '0;
            k  <= '0;
            st <= S_SEQ;
          end else begin
            gc <= gc + 1'b1;
          end
        S_SEQ: begin
          if (nr == '0) begin
            case (k)
              3'd0:    clr_q <= 1'b0;
              3'd1:    clr_q <= 1'b1;
              3'd2:    dat_q <= 1'b1;
              3'd3:    clk_q <= 1'b1;
              3'd4:    clk_q <= 1'b0;
              default: dat_q <= 1'b0;
            endcase
          end else begin
            clk_q <= (k == 3'd0);
          end
          if (k == k_last) st <= S_POST;
          else             k  <= k + 1'b1;
        end
        S_POST:
          if (gc == GW'(GUARD_POST - 1)) begin
            gc    <= '0;
            col_q <= mapped;
            lim   <= lim_of(np);
            np    <= p_next(np);
            st    <= S_DWELL;
          end else begin
            gc <= gc + 1'b1;
          end
        default: st <= S_DWELL;
      endcase
    end
  end

  a_r2_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= lim);

  a_r4_strobe_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable({row_clr_n, row_clk, row_dat})) |-> col == '0);

  a_r5_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
    row_dat |-> (row_clr_n && col == '0));

  a_r6_clk_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_clk) |=> !row_clk);

  a_r11_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (col == '0 && !row_clk && !row_dat && !row_clr_n));
endmodule

// File: tb/led_plane_scan_bench.sv
module scan_mon #(
  parameter int ROWS       = 4,
  parameter int PLANES     = 3,
  parameter int PRESCALE   = 4,
  parameter logic [PLANES*8-1:0] PLANE_CMP = {8'd22, 8'd4, 8'd3},
  parameter int CMP_INIT   = 20,
  parameter int GUARD_PRE  = 10,
  parameter int GUARD_POST = 20,
  parameter bit INTERLACE  = 1'b0,
  parameter bit REVERSE    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [15:0] col,
  input  logic        clr_n,
  input  logic        rclk,
  input  logic        rdat,
  output int          n_chk,
  output int          n_err,
  output int          n_rows
);
  int chk_cnt = 0, err_cnt = 0, row_cnt = 0;
  assign n_chk  = chk_cnt;
  assign n_err  = err_cnt;
  assign n_rows = row_cnt;

  logic [ROWS-1:0] sr;
  logic [15:0]     prev_col;
  logic [2:0]      prev_s, s;
  logic            prev_clk, lost, started;
  int z, nchg, fch, lch, seg, exp_r, exp_p, base, rn, n;

  function automatic int dwell(input int p);
    return (int'(PLANE_CMP[p*8 +: 8]) + 1) * PRESCALE;
  endfunction

  function automatic logic [15:0] expect_col(input int r, input int p);
    int fr;
    logic [7:0] lo;
    logic [15:0] d, o;
    fr = INTERLACE ? ((r / 2) + ((r % 2 == 1) ? ROWS / 2 : 0)) : r;
    lo = 8'(fr * 8 + p + 1);
    d  = {lo ^ 8'hA5, lo};
    for (int i = 0; i < 16; i++) o[i] = REVERSE ? d[15-i] : d[i];
    return o;
  endfunction

  task automatic chk(input string req, input int got, input int expv);
    chk_cnt++;
    if (got != expv) begin
      err_cnt++;
      $display("FAIL %s got %0d exp %0d", req, got, expv);
    end
  endtask

  task automatic chk_ge(input string req, input int got, input int lo);
    chk_cnt++;
    if (got < lo) begin
      err_cnt++;
      $display("FAIL %s got %0d exp >= %0d", req, got, lo);
    end
  endtask

  string vlabel;
  initial vlabel = (INTERLACE || REVERSE) ? "R9 R10" : "R8";

  always @(negedge clk) begin
    if (!rst_n) begin
      sr = '0; prev_col = '0; prev_s = '0; prev_clk = 1'b0;
      lost = 1'b0; started = 1'b0;
      z = 0; nchg = 0; fch = 0; lch = 0; seg = 0; exp_r = 0; exp_p = 0;
    end else if (!en) begin
      chk("R11", int'({col, clr_n, rclk, rdat}), 0);
      lost = 1'b1;
    end else begin
      s = {clr_n, rclk, rdat};
      if (!clr_n) sr = '0;
      else if (rclk && !prev_clk) begin
        sr = {sr[ROWS-2:0], rdat};
        if (rdat) lost = 1'b0;
      end
      prev_clk = rclk;
      if (col == '0) begin
        if (prev_col != '0) begin
          chk("R2", seg, dwell(exp_p));
          chk("R3", exp_p, PLANES - 1);
          z = 0; nchg = 0; fch = 0; lch = 0;
        end
        z++;
        if (s != prev_s) begin
          nchg++;
          if (nchg == 1) fch = z;
          lch = z;
        end
      end else if (prev_col == '0) begin
        base = started ? 0 : (CMP_INIT + 1) * PRESCALE;
        rn   = started ? (exp_r + 1) % ROWS : 0;
        n    = (rn == 0) ? 6 : 2;
        chk(started ? "R7" : "R1", z, base + GUARD_PRE + n + GUARD_POST);
        chk_ge("R4", fch, base + GUARD_PRE + 2);
        chk("R7", lch, base + GUARD_PRE + n + 1);
        if (!lost) chk((rn == 0) ? "R5" : "R6", int'(sr), 1 << rn);
        if (started) row_cnt++;
        exp_r = rn; exp_p = 0; started = 1'b1; seg = 1;
        chk(vlabel, int'(col), int'(expect_col(exp_r, exp_p)));
      end else if (col != prev_col) begin
        chk("R2", seg, dwell(exp_p));
        chk("R3", (exp_p + 1 < PLANES) ? 1 : 0, 1);
        exp_p++; seg = 1;
        chk(vlabel, int'(col), int'(expect_col(exp_r, exp_p)));
      end else begin
        seg++;
      end
      prev_col = col;
      prev_s   = s;
    end
  end
endmodule

module led_plane_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int PRESC = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0]  fr_a, fr_b, fp_a, fp_b;
  logic [15:0] fd_a, fd_b, col_a, col_b;
  logic        clr_a, ck_a, dt_a, clr_b, ck_b, dt_b;

  function automatic logic [15:0] fb(input logic [1:0] r, input logic [1:0] p);
    logic [7:0] lo;
    lo = 8'(int'(r) * 8 + int'(p) + 1);
    return {lo ^ 8'hA5, lo};
  endfunction
  assign fd_a = fb(fr_a, fp_a);
  assign fd_b = fb(fr_b, fp_b);

  led_plane_scan #(.ROWS(ROWS), .PRESCALE(PRESC)) u_led_plane_scan (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_data(fd_a), .fb_row(fr_a),
    .fb_plane(fp_a), .col(col_a), .row_clr_n(clr_a), .row_clk(ck_a), .row_dat(dt_a));

  led_plane_scan #(.ROWS(ROWS), .PRESCALE(PRESC), .INTERLACE(1'b1), .REVERSE(1'b1)) u_led_plane_scan_x (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_data(fd_b), .fb_row(fr_b),
    .fb_plane(fp_b), .col(col_b), .row_clr_n(clr_b), .row_clk(ck_b), .row_dat(dt_b));

  int c_a, e_a, r_a, c_b, e_b, r_b;
  scan_mon #(.ROWS(ROWS), .PRESCALE(PRESC)) u_mon_a (
    .clk(clk), .rst_n(rst_n), .en(en), .col(col_a), .clr_n(clr_a), .rclk(ck_a),
    .rdat(dt_a), .n_chk(c_a), .n_err(e_a), .n_rows(r_a));
  scan_mon #(.ROWS(ROWS), .PRESCALE(PRESC), .INTERLACE(1'b1), .REVERSE(1'b1)) u_mon_b (
    .clk(clk), .rst_n(rst_n), .en(en), .col(col_b), .clr_n(clr_b), .rclk(ck_b),
    .rdat(dt_b), .n_chk(c_b), .n_err(e_b), .n_rows(r_b));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks + c_a + c_b, errors + e_a + e_b);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'({col_a, clr_a, ck_a, dt_a}), 0);
    chk("R1", int'({col_b, clr_b, ck_b, dt_b}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (1500) @(posedge clk);
    #1 en = 1'b0;
    repeat (37) @(posedge clk);
    #1 en = 1'b1;
    repeat (1500) @(posedge clk);
    #1 en = 1'b0;
    repeat (5) @(posedge clk);
    #1 en = 1'b1;
    repeat (700) @(posedge clk);
    @(negedge clk);
    chk_rows();
    done = 1'b1;
    finish_run();
  end

  task automatic chk_rows();
    checks += 2;
    if (r_a < 12) begin errors++; $display("FAIL R3 rows got %0d exp >= 12", r_a); end
    if (r_b < 12) begin errors++; $display("FAIL R3 rows got %0d exp >= 12", r_b); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog got hung exp finish");
      finish_run();
    end
  end
endmodule